// File: doc/BRIEF.md
# Programmable Reference Clock Divider with Settle Flag

This block divides a reference clock by an integer held in a 32-bit control word. The word is written and read through a simple single-cycle port. A write can update the divider field, set the output enable, start a timed reset pulse for a downstream clock domain, and request that the divider field be applied. The new divisor takes effect only on that apply request, called the load strobe. After a load, a settle flag drops and comes back once a window proportional to the new divisor has passed. Software can then re-open the output. The flag can be reported at bit 31 or at bit 27.

Three parameters pick the variant. A gated variant shuts the output on every load and lets it open again only after the flag returns. An ungated variant has no enable and keeps running across a change. A variant that cannot divide by one to three stores a safe replacement code instead. A divider code of 0 or 1 passes the reference clock straight through, gated by the enable.

Top module: `refdiv_ctrl`

## Requirements
- R1: After reset the read word has only the settle flag set, the output and the domain-reset pulse are low, and the applied divisor is 1.
- R2: The divider code lives in read/write bits [4 +: DIV_W]. Writing it without bit 2 (load strobe) leaves the output period unchanged. Bit 2 always reads 0.
- R3: For an applied divisor D of 2 or more, with the output enabled, each output period is D reference cycles: floor(D/2) cycles high, then the rest low.
- R4: For an applied code of 0 or 1, the output equals the reference clock ANDed with the enable.
- R5: The settle flag reads 0 in the cycle after a load-strobe write. It reads 1 again exactly 4*max(D,1) reference cycles after that write edge.
- R6: The settle flag is read at bit 31 when LOCK_ALT=0 and at bit 27 when LOCK_ALT=1.
- R7: (GATED=1) A load-strobe write clears enable (bit 0). The output is held low whenever enable reads 0.
- R8: (GATED=1) A write that sets bit 0 while the settle flag is 0 is ignored, so bit 0 stays 0.
- R9: (GATED=0) Bit 0 reads 0 and ignores writes. The output runs without an enable.
- R10: (SKIP_SMALL=1) A written code of 1 or 2 is stored as 0, a code of 3 is stored as 4, and other codes are kept as written.
- R11: Writing bit 1 starts a domain-reset pulse lasting exactly REF_MHZ reference cycles, which is 1 µs. Bit 1 reads 1 while the pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control/status word |
| div_clk_o | output | 1 | Divided (or passed-through) output clock |
| dom_rst_o | output | 1 | Downstream domain reset pulse |

## Verification
The bench builds two instances. The first is gated, keeps the flag at bit 31, uses a 6-bit field and runs at 100 MHz. It reaches the load-and-re-enable flow, the rejected early enable, odd, even and maximum divisors, the pass-through code and a 100-cycle reset pulse. The second is ungated, remaps small codes, reports the flag at bit 27 and is set for 5 MHz. It reaches the relocated flag, the absent enable, the code remapping and a short pulse.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int EN_BIT     = 0;
    localparam int DOMRST_BIT = 1;
    localparam int LOAD_BIT   = 2;
    localparam int FIELD_LSB  = 4;
    localparam int FLAG_MAIN  = 31;
    localparam int FLAG_ALT   = 27;

    typedef struct packed {
        logic enable;
        logic dom_reset;
        logic load;
    } ctl_flags_t;

    function automatic ctl_flags_t decode_flags(logic [31:0] w);
        ctl_flags_t f;
        f.enable    = w[EN_BIT];
        f.dom_reset = w[DOMRST_BIT];
        f.load      = w[LOAD_BIT];
        return f;
    endfunction

    // Replace codes the small-divisor-less variant cannot produce.
    function automatic logic [31:0] remap_code(logic [31:0] c, bit skip_small);
        logic [31:0] r;
        r = c;
        if (skip_small) begin
            if (c == 32'd1 || c == 32'd2) r = 32'd0;
            else if (c == 32'd3)          r = 32'd4;
        end
        return r;
    endfunction

endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs
    import refdiv_pkg::*;
#(
    parameter int DIV_W      = 6,
    parameter bit GATED      = 1'b1,
    parameter bit SKIP_SMALL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             settled,
    output logic [DIV_W-1:0] code_q,
    output logic [DIV_W-1:0] code_next,
    output logic             en_q,
    output logic             load_p,
    output logic             dom_req
);
    ctl_flags_t  flags;
    logic [31:0] mapped;

    always_comb begin
        flags     = decode_flags(wr_data);
        mapped    = remap_code({{(32-DIV_W){1'b0}}, wr_data[FIELD_LSB +: DIV_W]}, SKIP_SMALL);
        code_next = mapped[DIV_W-1:0];
        load_p    = wr_en && flags.load;
        dom_req   = wr_en && flags.dom_reset;
    end

    always_ff @(posedge clk) begin
        if (rst)        code_q <= '0;
        else if (wr_en) code_q <= code_next;
    end

    generate
        if (GATED) begin : g_gate
            always_ff @(posedge clk) begin
                if (rst)                     en_q <= 1'b0;
                else if (load_p)             en_q <= 1'b0;
                else if (wr_en && settled)   en_q <= flags.enable;
            end
        end else begin : g_free
            assign en_q = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/refdiv_gen.sv
module refdiv_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [DIV_W-1:0] new_code,
    output logic             clk_out
);
    logic [DIV_W-1:0] active_q, cnt_q, cnt_nx;
    logic [DIV_W-1:0] eff_act, eff_new;
    logic             phase_q, bypass;

    always_comb begin
        eff_act = (active_q == '0) ? DIV_W'(1) : active_q;
        eff_new = (new_code == '0) ? DIV_W'(1) : new_code;
        cnt_nx  = (cnt_q >= eff_act - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
        bypass  = (eff_act == DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            cnt_q    <= '0;
            phase_q  <= 1'b0;
        end else if (load) begin
            active_q <= new_code;
            cnt_q    <= '0;
            phase_q  <= ((eff_new >> 1) != '0);
        end else begin
            cnt_q    <= cnt_nx;
            phase_q  <= (cnt_nx < (eff_act >> 1));
        end
    end

    assign clk_out = bypass ? (clk & en) : (phase_q & en);
endmodule

// File: rtl/refdiv_settle.sv
module refdiv_settle #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] new_code,
    output logic             settled
);
    localparam int CW = DIV_W + 2;
    logic [CW-1:0] cnt_q, window;

    always_comb begin
        window = (new_code == '0) ? CW'(4) : ({2'b00, new_code} << 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            settled <= 1'b1;
        end else if (load) begin
            cnt_q   <= window - CW'(1);
            settled <= 1'b0;
        end else if (!settled) begin
            if (cnt_q == '0) settled <= 1'b1;
            else             cnt_q   <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/refdiv_rstpulse.sv
module refdiv_rstpulse #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (req && cnt_q == '0) cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
    import refdiv_pkg::*;
#(
    parameter int DIV_W      = 6,
    parameter bit GATED      = 1'b1,
    parameter bit SKIP_SMALL = 1'b0,
    parameter bit LOCK_ALT   = 1'b0,
    parameter int REF_MHZ    = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        div_clk_o,
    output logic        dom_rst_o
);
    localparam int FLAG_POS = LOCK_ALT ? FLAG_ALT : FLAG_MAIN;

    logic [DIV_W-1:0] code_q, code_next;
    logic             en_q, load_p, dom_req, settled;

    refdiv_regs #(.DIV_W(DIV_W), .GATED(GATED), .SKIP_SMALL(SKIP_SMALL)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .settled(settled),
        .code_q(code_q), .code_next(code_next), .en_q(en_q),
        .load_p(load_p), .dom_req(dom_req)
    );

    refdiv_gen #(.DIV_W(DIV_W)) u_gen (
        .clk(clk), .rst(rst), .en(en_q), .load(load_p),
        .new_code(code_next), .clk_out(div_clk_o)
    );

    refdiv_settle #(.DIV_W(DIV_W)) u_settle (
        .clk(clk), .rst(rst), .load(load_p),
        .new_code(code_next), .settled(settled)
    );

    refdiv_rstpulse #(.CYCLES(REF_MHZ)) u_pulse (
        .clk(clk), .rst(rst), .req(dom_req), .pulse(dom_rst_o)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[EN_BIT]              = GATED ? en_q : 1'b0;
        rd_data[DOMRST_BIT]          = dom_rst_o;
        rd_data[FIELD_LSB +: DIV_W]  = code_q;
        rd_data[FLAG_POS]            = settled;
    end
endmodule

// File: rtl/refdiv_ctrl_chk.sv
module refdiv_ctrl_chk #(
    parameter int DIV_W      = 6,
    parameter bit GATED      = 1'b1,
    parameter bit SKIP_SMALL = 1'b0,
    parameter bit LOCK_ALT   = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        div_clk_o,
    input logic        dom_rst_o
);
    localparam int FP = LOCK_ALT ? 27 : 31;
    logic [DIV_W-1:0] fld;
    assign fld = rd_data[4 +: DIV_W];

    AST_LOAD_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[2]) |=> !rd_data[FP]); // R5

    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_data[2]); // R2

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[1]) |=> dom_rst_o); // R11

    generate
        if (GATED) begin : g_gated
            AST_CLOSED_IS_LOW: assert property (@(negedge clk) disable iff (rst)
                !rd_data[0] |-> !div_clk_o); // R7
            AST_EARLY_ENABLE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
                (!rd_data[FP] && !rd_data[0]) |=> !rd_data[0]); // R8
        end else begin : g_free
            AST_NO_ENABLE_BIT: assert property (@(posedge clk) disable iff (rst)
                !rd_data[0]); // R9
        end
        if (SKIP_SMALL) begin : g_skip
            AST_NO_SMALL_CODE: assert property (@(posedge clk) disable iff (rst)
                !(fld == DIV_W'(1) || fld == DIV_W'(2) || fld == DIV_W'(3))); // R10
        end
    endgenerate
endmodule

bind refdiv_ctrl refdiv_ctrl_chk #(
    .DIV_W(DIV_W), .GATED(GATED), .SKIP_SMALL(SKIP_SMALL), .LOCK_ALT(LOCK_ALT)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .div_clk_o(div_clk_o), .dom_rst_o(dom_rst_o)
);

// File: tb/refdiv_ctrl_tb.sv
module refdiv_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        wr_en = 1'b0, a_wr_en = 1'b0;
    logic [31:0] wr_data = '0, a_wr_data = '0;
    logic [31:0] rd_data, a_rd_data;
    logic        dclk, a_dclk, drst, a_drst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    refdiv_ctrl #(.DIV_W(6), .GATED(1'b1), .SKIP_SMALL(1'b0), .LOCK_ALT(1'b0), .REF_MHZ(100)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .div_clk_o(dclk), .dom_rst_o(drst));

    refdiv_ctrl #(.DIV_W(5), .GATED(1'b0), .SKIP_SMALL(1'b1), .LOCK_ALT(1'b1), .REF_MHZ(5)) u_alt (
        .clk(clk), .rst(rst), .wr_en(a_wr_en), .wr_data(a_wr_data),
        .rd_data(a_rd_data), .div_clk_o(a_dclk), .dom_rst_o(a_drst));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int hi_len(input int d);
        return d / 2;
    endfunction

    task automatic wr(input logic [31:0] d);
        wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic awr(input logic [31:0] d);
        a_wr_data = d; a_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        a_wr_en = 1'b0;
    endtask

    // Load a divisor, check gating, the rejected early enable and the flag window.
    task automatic load(input int d);
        int n;
        n = 4 * eff(d);
        wr((32'(d) << 4) | 32'h4);
        check(rd_data[0] == 1'b0, "R7 enable cleared by load", int'(rd_data[0]), 0);
        check(rd_data[31] == 1'b0, "R5 flag low after load", int'(rd_data[31]), 0);
        wr((32'(d) << 4) | 32'h1);
        check(rd_data[0] == 1'b0, "R8 early enable ignored", int'(rd_data[0]), 0);
        check(dclk == 1'b0, "R7 output low while closed", int'(dclk), 0);
        repeat (n - 2) @(negedge clk);
        check(rd_data[31] == 1'b0, "R5 flag still low at n-1", int'(rd_data[31]), 0);
        @(negedge clk);
        check(rd_data[31] == 1'b1, "R5 flag high at n", int'(rd_data[31]), 1);
        wr((32'(d) << 4) | 32'h1);
        check(rd_data[0] == 1'b1, "R7 enable after settle", int'(rd_data[0]), 1);
    endtask

    task automatic measure(input int d, input string req);
        int hi, lo, guard;
        logic prev;
        hi = 0; lo = 0; guard = 0;
        prev = dclk;
        while (guard < 300) begin
            @(negedge clk); guard++;
            if (!prev && dclk) break;
            prev = dclk;
        end
        hi = 1;
        while (guard < 600) begin
            @(negedge clk); guard++;
            if (dclk) hi++; else break;
        end
        lo = 1;
        while (guard < 900) begin
            @(negedge clk); guard++;
            if (!dclk) lo++; else break;
        end
        check(hi == hi_len(d), {req, " high phase"}, hi, hi_len(d));
        check(lo == d - hi_len(d), {req, " low phase"}, lo, d - hi_len(d));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rd_data == 32'h8000_0000, "R1 reset word", rd_data, 32'h8000_0000);
        check(dclk == 1'b0 && drst == 1'b0, "R1 outputs low", int'(dclk), 0);
        // R6 relocated flag on second instance
        check(a_rd_data == 32'h0800_0000, "R6 flag at bit 27", a_rd_data, 32'h0800_0000);

        // R4 pass-through after enabling with code 0
        wr(32'h1);
        @(posedge clk); #1;
        check(dclk == 1'b1, "R4 pass-through high phase", int'(dclk), 1);
        @(negedge clk);
        check(dclk == 1'b0, "R4 pass-through low phase", int'(dclk), 0);

        // R3 / R5 directed even divisor
        load(4);
        measure(4, "R3 div4");

        // R2 field write without strobe keeps the period
        wr((32'd6 << 4) | 32'h1);
        check(rd_data[9:4] == 6'd6, "R2 field readback", int'(rd_data[9:4]), 6);
        check(rd_data[2] == 1'b0, "R2 strobe reads zero", int'(rd_data[2]), 0);
        measure(4, "R2 old period kept");
        load(6);
        measure(6, "R2 new period after strobe");

        // R3 odd and maximum
        load(7);
        measure(7, "R3 div7");
        load(63);
        measure(63, "R3 div63");

        // R3 random divisors
        for (int i = 0; i < 8; i++) begin
            int d;
            d = 2 + int'($urandom_range(61));
            load(d);
            measure(d, "R3 random");
        end

        // R4 / R5 code 0 again, window of 4
        load(0);
        @(posedge clk); #1;
        check(dclk == 1'b1, "R4 code zero passes clock", int'(dclk), 1);
        @(negedge clk);

        // R11 domain reset pulse on main instance
        wr((32'd0 << 4) | 32'h3);
        check(rd_data[1] == 1'b1, "R11 busy bit reads 1", int'(rd_data[1]), 1);
        cnt = 1;
        while (drst && cnt < 500) begin @(negedge clk); if (drst) cnt++; end
        check(cnt == 100, "R11 pulse length main", cnt, 100);

        // R9 no enable bit on ungated instance
        awr(32'h1);
        check(a_rd_data[0] == 1'b0, "R9 enable bit absent", int'(a_rd_data[0]), 0);
        @(posedge clk); #1;
        check(a_dclk == 1'b1, "R9 output runs ungated", int'(a_dclk), 1);
        @(negedge clk);

        // R10 small-code remapping
        awr(32'd1 << 4);
        check(a_rd_data[8:4] == 5'd0, "R10 code 1 stored as 0", int'(a_rd_data[8:4]), 0);
        awr(32'd2 << 4);
        check(a_rd_data[8:4] == 5'd0, "R10 code 2 stored as 0", int'(a_rd_data[8:4]), 0);
        awr(32'd3 << 4);
        check(a_rd_data[8:4] == 5'd4, "R10 code 3 stored as 4", int'(a_rd_data[8:4]), 4);
        awr(32'd5 << 4);
        check(a_rd_data[8:4] == 5'd5, "R10 code 5 kept", int'(a_rd_data[8:4]), 5);

        // R6 flag at 27 drops on load in alt instance
        awr((32'd5 << 4) | 32'h4);
        check(a_rd_data[27] == 1'b0 && a_rd_data[31] == 1'b0, "R6 flag bit 27 low after load",
              int'(a_rd_data[27]), 0);

        // R11 short pulse on alt instance
        awr(32'h2);
        cnt = 1;
        while (a_drst && cnt < 500) begin @(negedge clk); if (a_drst) cnt++; end
        check(cnt == 5, "R11 pulse length alt", cnt, 5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule